// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns the system clock into CAN bit timing. A programmable divider cuts the clock into time quanta. Every bit starts with one synchronization quantum. A first phase segment follows, then the sample point, then a second phase segment. The block raises a one-clock `sample_strobe` at the sample point. It raises a one-clock `tx_strobe` each time a new bit begins, which is where a transmitter launches its next bit.

The timing values live in one 32-bit register. That register can be written only while `cfg_en` is high. Each field holds the length it controls minus one. The divider is the concatenation of a 4-bit extension field above a 6-bit base field, which gives up to 1024 clocks per quantum.

While the bus is in use, a recessive-to-dominant transition on `rx` moves the bit boundary. This resynchronization is bounded by the jump width, and only one is allowed per bit. While `bus_idle` is high, such a transition hard-synchronizes the block instead.

Top module: `can_bittime_gen`

## Requirements
- R1: After reset, `rd_data` reads 0x0000_2301. The field values are: divider base 1, extension 0, first segment 3, second segment 2, jump width 0.
- R2: A write with `wr_en` and `cfg_en` both high stores `wr_data` into the fields, and `rd_data` reflects it from the next clock. The field positions are: divider base in bits 5:0, jump width in 7:6, first segment in 11:8, second segment in 14:12, extension in 19:16. Bits 15 and 31:20 read as zero.
- R3: A write while `cfg_en` is low changes neither `rd_data` nor the bit timing.
- R4: A quantum lasts D = {extension, base} + 1 clocks. With no `rx` edge, one `tx_strobe` follows the previous one by D × (1 + L1 + L2) clocks. Here L1 = first segment + 1 and L2 = second segment + 1. `tx_strobe` is high for one clock.
- R5: `sample_strobe` is high for one clock, D × (1 + L1) clocks after the `tx_strobe` that opened the bit.
- R6: A programmed first segment of 0 acts as 1, so L1 = 2.
- R7: While `bus_idle` is low, a falling `rx` edge seen in quantum k (counting from 0) of the first segment lengthens that segment by min(k + 1, SJW + 1) quanta.
- R8: While `bus_idle` is low, a falling `rx` edge seen in quantum q (counting from 0) of the second segment shortens that segment by min(L2 − 1 − q, SJW + 1) quanta.
- R9: A falling `rx` edge seen in the sync quantum changes no timing, and it uses up that bit's one resynchronization.
- R10: Only the first falling `rx` edge of a bit can adjust the bit. Later edges in the same bit have no effect.
- R11: While `bus_idle` is high, a falling `rx` edge restarts the bit at the sync segment. `tx_strobe` is high in the following clock, and `sample_strobe` comes D × (1 + L1) clocks after that restart.
- R12: `sample_strobe` and `tx_strobe` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Configuration change enable; writes are accepted only when high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Current register contents |
| rx | input | 1 | Receive line, 1 = recessive |
| bus_idle | input | 1 | High while the bus is idle; selects hard synchronization |
| sample_strobe | output | 1 | One-clock pulse at the sample point |
| tx_strobe | output | 1 | One-clock pulse at the start of each bit |

## Verification
The assertions assume three things about the inputs:
- `rx` is already synchronous to `clk` and sits recessive during reset.
- No write arrives in the same clock as a reset release.
- A hard-synchronizing edge is qualified by the `rx` level of the previous clock.

For the resynchronization tests, the stimulus uses quanta of at least three clocks. Each falling edge is placed in the first clock of a quantum, so it never meets a quantum boundary in the same cycle. `rx` always returns to recessive one clock after it falls. Edges in the same bit are at least one quantum apart. Configuration writes happen mid-bit, and the bench measures only from the next bit boundary onward.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  localparam int REG_W   = 32;
  localparam int BRP_W   = 6;
  localparam int SJW_W   = 2;
  localparam int TS1_W   = 4;
  localparam int TS2_W   = 3;
  localparam int EXT_W   = 4;
  localparam int BRP_LSB = 0;
  localparam int SJW_LSB = 6;
  localparam int TS1_LSB = 8;
  localparam int TS2_LSB = 12;
  localparam int EXT_LSB = 16;
  localparam int DIV_W   = BRP_W + EXT_W;
  localparam int QC_W    = TS1_W + 2;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_TS1  = 2'd1,
    SEG_TS2  = 2'd2
  } seg_e;

  typedef struct packed {
    logic [EXT_W-1:0] ext;
    logic [TS2_W-1:0] ts2;
    logic [TS1_W-1:0] ts1;
    logic [SJW_W-1:0] sjw;
    logic [BRP_W-1:0] brp;
  } bt_cfg_t;

  localparam bt_cfg_t CFG_RST = '{ext: '0, ts2: 3'd2, ts1: 4'd3, sjw: '0, brp: 6'd1};
endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg
  import can_bt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output bt_cfg_t          cfg_q,
  output logic [REG_W-1:0] rd_data
);
  bt_cfg_t cfg_d;
  logic    load;

  always_comb begin
    load  = wr_en & cfg_en;
    cfg_d = cfg_q;
    if (load) begin
      cfg_d.brp = wr_data[BRP_LSB +: BRP_W];
      cfg_d.sjw = wr_data[SJW_LSB +: SJW_W];
      cfg_d.ts1 = wr_data[TS1_LSB +: TS1_W];
      cfg_d.ts2 = wr_data[TS2_LSB +: TS2_W];
      cfg_d.ext = wr_data[EXT_LSB +: EXT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST;
    end else if (load) begin
      cfg_q <= cfg_d;
    end
  end

  always_comb begin
    rd_data                     = '0;
    rd_data[BRP_LSB +: BRP_W]   = cfg_q.brp;
    rd_data[SJW_LSB +: SJW_W]   = cfg_q.sjw;
    rd_data[TS1_LSB +: TS1_W]   = cfg_q.ts1;
    rd_data[TS2_LSB +: TS2_W]   = cfg_q.ts2;
    rd_data[EXT_LSB +: EXT_W]   = cfg_q.ext;
  end
endmodule

// File: rtl/can_bt_tq.sv
module can_bt_tq
  import can_bt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_m1,
  input  logic             restart,
  output logic             tq_tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;

  // Greater-or-equal keeps the divider safe when the ratio shrinks mid-quantum
  assign tq_tick = (cnt_q >= div_m1);

  always_comb begin
    if (restart || tq_tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/can_bt_seg.sv
module can_bt_seg
  import can_bt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tq_tick,
  input  bt_cfg_t cfg,
  input  logic    rx,
  input  logic    bus_idle,
  output logic    hsync,
  output logic    sample_q,
  output logic    txpt_q
);
  seg_e            seg_q, seg_d;
  logic [QC_W-1:0] qcnt_q, qcnt_d;
  logic [QC_W-1:0] ext_q, ext_d;
  logic [QC_W-1:0] sh_q, sh_d;
  logic            done_q, done_d;
  logic            rx_q;
  logic            smp_d, tx_d;
  logic            fall;
  logic [QC_W-1:0] l1, l2, sjw1, qnext, lng, rem2, shr;

  always_comb begin
    l1    = (cfg.ts1 == '0) ? QC_W'(2) : QC_W'(cfg.ts1) + QC_W'(1);
    l2    = QC_W'(cfg.ts2) + QC_W'(1);
    sjw1  = QC_W'(cfg.sjw) + QC_W'(1);
    qnext = qcnt_q + QC_W'(1);
    lng   = (qnext < sjw1) ? qnext : sjw1;
    rem2  = (qnext >= l2) ? '0 : (l2 - qnext);
    shr   = (rem2 < sjw1) ? rem2 : sjw1;
    fall  = rx_q & ~rx;
    hsync = fall & bus_idle;
  end

  always_comb begin
    seg_d  = seg_q;
    qcnt_d = qcnt_q;
    ext_d  = ext_q;
    sh_d   = sh_q;
    done_d = done_q;
    smp_d  = 1'b0;
    tx_d   = 1'b0;
    if (hsync) begin
      seg_d  = SEG_SYNC;
      qcnt_d = '0;
      ext_d  = '0;
      sh_d   = '0;
      done_d = 1'b0;
      tx_d   = 1'b1;
    end else begin
      if (fall && !done_q) begin
        done_d = 1'b1;
        if (seg_q == SEG_TS1) begin
          ext_d = lng;
        end else if (seg_q == SEG_TS2) begin
          sh_d = shr;
        end
      end
      if (tq_tick) begin
        case (seg_q)
          SEG_SYNC: begin
            seg_d  = SEG_TS1;
            qcnt_d = '0;
          end
          SEG_TS1: begin
            if (qnext >= l1 + ext_d) begin
              seg_d  = SEG_TS2;
              qcnt_d = '0;
              smp_d  = 1'b1;
            end else begin
              qcnt_d = qnext;
            end
          end
          SEG_TS2: begin
            if (qnext + sh_d >= l2) begin
              seg_d  = SEG_SYNC;
              qcnt_d = '0;
              ext_d  = '0;
              sh_d   = '0;
              done_d = 1'b0;
              tx_d   = 1'b1;
            end else begin
              qcnt_d = qnext;
            end
          end
          default: begin
            seg_d  = SEG_SYNC;
            qcnt_d = '0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q    <= SEG_SYNC;
      qcnt_q   <= '0;
      ext_q    <= '0;
      sh_q     <= '0;
      done_q   <= 1'b0;
      rx_q     <= 1'b1;
      sample_q <= 1'b0;
      txpt_q   <= 1'b0;
    end else begin
      seg_q    <= seg_d;
      qcnt_q   <= qcnt_d;
      ext_q    <= ext_d;
      sh_q     <= sh_d;
      done_q   <= done_d;
      rx_q     <= rx;
      sample_q <= smp_d;
      txpt_q   <= tx_d;
    end
  end
endmodule

// File: rtl/can_bittime_gen.sv
module can_bittime_gen
  import can_bt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             rx,
  input  logic             bus_idle,
  output logic             sample_strobe,
  output logic             tx_strobe
);
  bt_cfg_t          cfg;
  logic             tq_tick;
  logic             hsync;
  logic [DIV_W-1:0] div_m1;

  assign div_m1 = {cfg.ext, cfg.brp};

  can_bt_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_en  (cfg_en),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cfg_q   (cfg),
    .rd_data (rd_data)
  );

  can_bt_tq u_tq (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_m1  (div_m1),
    .restart (hsync),
    .tq_tick (tq_tick)
  );

  can_bt_seg u_seg (
    .clk      (clk),
    .rst_n    (rst_n),
    .tq_tick  (tq_tick),
    .cfg      (cfg),
    .rx       (rx),
    .bus_idle (bus_idle),
    .hsync    (hsync),
    .sample_q (sample_strobe),
    .txpt_q   (tx_strobe)
  );
endmodule

// File: rtl/can_bittime_chk.sv
module can_bittime_chk
  import can_bt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_en,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             rx,
  input logic             bus_idle,
  input logic             sample_strobe,
  input logic             tx_strobe
);
  localparam logic [REG_W-1:0] WR_MASK = {{(REG_W-EXT_LSB-EXT_W){1'b0}}, {EXT_W{1'b1}}, 1'b0,
                                          {TS2_W{1'b1}}, {TS1_W{1'b1}}, {SJW_W{1'b1}}, {BRP_W{1'b1}}};

  p_cfg_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cfg_en) |=> (rd_data == ($past(wr_data) & WR_MASK)));

  p_cfg_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(rd_data));

  p_sample_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |=> !sample_strobe);

  p_hard_sync_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_idle && $past(rx) && !rx) |=> tx_strobe);

  p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_strobe && tx_strobe));
endmodule

bind can_bittime_gen can_bittime_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_en        (cfg_en),
  .wr_en         (wr_en),
  .wr_data       (wr_data),
  .rd_data       (rd_data),
  .rx            (rx),
  .bus_idle      (bus_idle),
  .sample_strobe (sample_strobe),
  .tx_strobe     (tx_strobe)
);

// File: tb/can_bittime_gen_tb_top.sv
`timescale 1ns/1ps
module can_bittime_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_en;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        rx;
  logic        bus_idle;
  logic        sample_strobe;
  logic        tx_strobe;

  int checks = 0;
  int errors = 0;
  int overlaps = 0;

  always #2.5 clk = ~clk;

  can_bittime_gen dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_en        (cfg_en),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .rd_data       (rd_data),
    .rx            (rx),
    .bus_idle      (bus_idle),
    .sample_strobe (sample_strobe),
    .tx_strobe     (tx_strobe)
  );

  always @(negedge clk) begin
    if (rst_n && sample_strobe && tx_strobe) overlaps++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic wr(input bit en, input logic [31:0] d);
    @(negedge clk);
    cfg_en  = en;
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en  = 1'b0;
    cfg_en = 1'b0;
  endtask

  task automatic sync_to_tx();
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (tx_strobe) break;
    end
  endtask

  // Offsets in clocks from the opening tx_strobe edge; d = clock whose edge sees rx fall
  task automatic run_bit(input int d1, input int d2, output int ts, output int tt);
    ts = -1;
    tt = -1;
    for (int i = 1; i < 40000; i++) begin
      @(negedge clk);
      if (sample_strobe && ts < 0) ts = i;
      if (tx_strobe) begin
        tt = i;
        rx = 1'b1;
        break;
      end
      rx = !((i == d1 - 1) || (i == d2 - 1));
    end
  endtask

  function automatic void exp_bit(input int dv, input int l1, input int l2, input int sj,
                                  input int d1, input int d2, output int es, output int et);
    int  ext;
    int  sh;
    int  qi;
    int  r;
    bit  done;
    int  ds [2];
    ext = 0; sh = 0; done = 1'b0;
    ds[0] = d1; ds[1] = d2;
    for (int n = 0; n < 2; n++) begin
      if (ds[n] > 0 && !done) begin
        done = 1'b1;
        qi = (ds[n] - 1) / dv;
        if (qi == 0) begin
          ext = 0;
        end else if (qi <= l1) begin
          ext = (qi < sj) ? qi : sj;
        end else begin
          r  = l2 - 1 - (qi - 1 - l1);
          if (r < 0) r = 0;
          sh = (r < sj) ? r : sj;
        end
      end
    end
    es = dv * (1 + l1 + ext);
    et = dv * (1 + l1 + ext + l2 - sh);
  endfunction

  task automatic bit_case(input int dv, input int l1, input int l2, input int sj,
                          input int d1, input int d2, input string tag);
    int ts, tt, es, et;
    exp_bit(dv, l1, l2, sj, d1, d2, es, et);
    run_bit(d1, d2, ts, tt);
    chk(ts == es, {tag, " sample"}, ts, es);
    chk(tt == et, {tag, " bit end"}, tt, et);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed_init;
    int n;
    rst_n = 1'b0; cfg_en = 1'b0; wr_en = 1'b0; wr_data = '0; rx = 1'b1; bus_idle = 1'b0;
    seed_init = $urandom(32'h5EED_0042);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset contents
    chk(rd_data == 32'h0000_2301, "R1 reset value", rd_data, 32'h0000_2301);
    sync_to_tx();
    bit_case(2, 4, 3, 1, 0, 0, "R4 R5 reset timing");

    // R3 locked write
    wr(1'b0, 32'hFFFF_FFFF);
    chk(rd_data == 32'h0000_2301, "R3 locked readback", rd_data, 32'h0000_2301);
    sync_to_tx();
    bit_case(2, 4, 3, 1, 0, 0, "R3 timing kept");

    // R2 reserved bits read zero
    wr(1'b1, 32'hFFFF_FFFF);
    chk(rd_data == 32'h000F_7FFF, "R2 all ones", rd_data, 32'h000F_7FFF);

    // R4 largest divider: ext 15, base 63, ts1 1, ts2 0
    wr(1'b1, 32'h000F_013F);
    chk(rd_data == 32'h000F_013F, "R2 field write", rd_data, 32'h000F_013F);
    sync_to_tx();
    bit_case(1024, 2, 1, 1, 0, 0, "R4 divide 1024");

    // R6 first segment programmed 0: base 2, ts2 1
    wr(1'b1, 32'h0000_1002);
    sync_to_tx();
    bit_case(3, 2, 2, 1, 0, 0, "R6 ts1 zero");

    // div 4, L1 6, L2 5, SJW+1 2
    wr(1'b1, 32'h0000_4543);
    sync_to_tx();
    bit_case(4, 6, 5, 2, 17, 0, "R7 lengthen capped");
    bit_case(4, 6, 5, 2, 5, 0, "R7 lengthen one");
    bit_case(4, 6, 5, 2, 33, 0, "R8 shorten capped");
    bit_case(4, 6, 5, 2, 45, 0, "R8 last quantum");
    bit_case(4, 6, 5, 2, 2, 33, "R9 sync edge");
    bit_case(4, 6, 5, 2, 17, 41, "R10 second edge");

    // R11 hard sync mid-bit
    repeat (11) @(negedge clk);
    bus_idle = 1'b1;
    rx = 1'b0;
    @(negedge clk);
    chk(tx_strobe == 1'b1, "R11 restart strobe", tx_strobe, 1);
    rx = 1'b1;
    bus_idle = 1'b0;
    n = 0;
    for (int i = 1; i < 1000; i++) begin
      @(negedge clk);
      if (sample_strobe) begin n = i; break; end
    end
    chk(n == 28, "R11 sample after restart", n, 28);

    // Random configurations and edge placements
    for (int it = 0; it < 24; it++) begin
      int brp, ts1, ts2, sjw, dv, l1, l2, sj, mode, d1, d2;
      logic [31:0] v;
      string tag;
      brp  = $urandom_range(2, 7);
      ts1  = $urandom_range(0, 15);
      ts2  = $urandom_range(0, 7);
      sjw  = $urandom_range(0, 3);
      dv   = brp + 1;
      l1   = (ts1 == 0) ? 2 : ts1 + 1;
      l2   = ts2 + 1;
      sj   = sjw + 1;
      v    = 32'(brp) | (32'(sjw) << 6) | (32'(ts1) << 8) | (32'(ts2) << 12);
      wr(1'b1, v);
      chk(rd_data == v, "R2 random write", rd_data, v);
      sync_to_tx();
      mode = $urandom_range(0, 4);
      d1 = 0; d2 = 0;
      case (mode)
        1: begin d1 = dv * (1 + $urandom_range(0, l1 - 1)) + 1; tag = "R7 random"; end
        2: begin d1 = dv * (1 + l1 + $urandom_range(0, l2 - 1)) + 1; tag = "R8 random"; end
        3: begin
             d1 = dv * (1 + $urandom_range(0, l1 - 1)) + 1;
             d2 = dv * (1 + l1 + $urandom_range(0, l2 - 1)) + 1;
             tag = "R10 random";
           end
        4: begin d1 = 2; tag = "R9 random"; end
        default: tag = "R4 random";
      endcase
      bit_case(dv, l1, l2, sj, d1, d2, tag);
    end

    chk(overlaps == 0, "R12 strobe overlap", overlaps, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule